// File: doc/BRIEF.md
# Address-Decoded Chip Select with Wait-State Insertion

This block sits beside a CPU with a 24-bit address bus and drives four chip-select lines for external memories and peripherals. Each channel is set up either as a memory decoder or as an I/O decoder. A memory decoder matches an inclusive range of 64 KB pages. An I/O decoder matches one 256-byte section of I/O space. When more than one enabled channel matches, the lowest-numbered one wins and is the only one asserted.

For every bus cycle that selects a channel, the block holds the CPU's ready line low for that channel's programmed wait count (0 to 7 clocks). After that it keeps ready low for as long as the external WAIT input is high. The channel setup arrives on static configuration inputs that a register bank elsewhere holds. A bus cycle is active while a request strobe (memory or I/O) is high together with a read or write strobe. The cycle starts in the first clock in which this is true after an idle clock. All strobes are active-high.

Top module: `csel_wait_gen`

## Requirements
- R1: At most one of the four chip-select outputs is high at any time, and none is high unless mreq or iorq is high.
- R2: A memory channel (its cfg_io bit 0) asserts while mreq is high and addr[23:16] is between its cfg_lo byte and its cfg_hi byte, both bounds included. Channel i uses byte i of cfg_lo and cfg_hi, that is bits [8i+7:8i].
- R3: An I/O channel (its cfg_io bit 1) asserts while iorq is high and addr[15:8] equals its cfg_lo byte. It ignores addr[23:16] and never responds to mreq. A memory channel never responds to iorq.
- R4: When several enabled channels match, only the lowest-numbered matching channel asserts.
- R5: A channel whose cfg_en bit is 0 never asserts and adds no wait states.
- R6: In a cycle that selects channel i, rdy is low in the first N clocks of the cycle, where N is cfg_wait[3i+2:3i]. With WAIT low it is high from clock N+1 onward, so N=0 gives a ready first clock.
- R7: Once the N wait clocks of a selected cycle have elapsed, rdy stays low while wait_in is high. It goes high in the first clock in which wait_in is low and the count has expired. WAIT seen during the count does not add to N.
- R8: A bus cycle that selects no channel has rdy high from its first clock, whatever wait_in does. rdy is also high whenever no bus cycle is active.
- R9: After reset, with no strobe active, all chip selects are low and rdy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 24 | CPU address bus |
| mreq | input | 1 | Memory request strobe |
| iorq | input | 1 | I/O request strobe |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wait_in | input | 1 | External WAIT request from a slow peripheral |
| cfg_en | input | 4 | Per-channel enable |
| cfg_io | input | 4 | Per-channel space: 0 memory, 1 I/O |
| cfg_lo | input | 32 | Per-channel lower page bound, or I/O section |
| cfg_hi | input | 32 | Per-channel upper page bound (memory channels) |
| cfg_wait | input | 12 | Per-channel wait count, 3 bits each |
| cs | output | 4 | Chip selects, active high |
| rdy | output | 1 | Ready back to the CPU, low stalls the cycle |

## Verification
The hardest situation to reach is one where the wait count and the external WAIT overlap. The bench has to tell whether the stall lasts as long as the longer of the two or as long as their sum, and whether WAIT is ignored on an unmatched cycle. The stimulus holds WAIT high for a chosen number of clocks from the start of each cycle. It measures the number of clocks with ready low and compares that with the larger of the programmed count and the WAIT length. It does this once with a WAIT shorter than the count, once with a longer one, and once on an address no channel claims. Overlapping memory ranges and a channel disabled mid-run show the priority and enable rules at the chip-select pins.

// File: rtl/csw_pkg.sv
package csw_pkg;
   localparam int CSW_ADDR_W  = 24;
   localparam int CSW_FIELD_W = 8;
   localparam int CSW_WAIT_W  = 3;
   localparam int CSW_CHANS   = 4;

   typedef enum logic {
      SPACE_MEM = 1'b0,
      SPACE_IO  = 1'b1
   } space_e;
endpackage

// File: rtl/csw_chan_match.sv
module csw_chan_match
   import csw_pkg::*;
#(
   parameter int AW      = CSW_ADDR_W,
   parameter int FW      = CSW_FIELD_W,
   parameter int MEM_LSB = 16,
   parameter int IO_LSB  = 8
) (
   input  logic          en,
   input  logic          space,
   input  logic [FW-1:0] lo,
   input  logic [FW-1:0] hi,
   input  logic [AW-1:0] addr,
   input  logic          mreq,
   input  logic          iorq,
   output logic          hit
);
   logic [FW-1:0] page;
   logic [FW-1:0] sect;
   logic          mem_hit;
   logic          io_hit;

   assign page    = addr[MEM_LSB +: FW];
   assign sect    = addr[IO_LSB +: FW];
   assign mem_hit = mreq && (page >= lo) && (page <= hi);
   assign io_hit  = iorq && (sect == lo);

   always_comb begin
      if (!en)
         hit = 1'b0;
      else if (space_e'(space) == SPACE_IO)
         hit = io_hit;
      else
         hit = mem_hit;
   end
endmodule

// File: rtl/csw_prio.sv
module csw_prio #(
   parameter int N = 4
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);
   logic taken;

   always_comb begin
      gnt   = '0;
      taken = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && !taken) begin
            gnt[i] = 1'b1;
            taken  = 1'b1;
         end
      end
   end
endmodule

// File: rtl/csw_wait_ctr.sv
module csw_wait_ctr #(
   parameter int WW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_act,
   input  logic          hit_any,
   input  logic [WW-1:0] wsel,
   input  logic          wait_in,
   output logic          rdy
);
   logic          act_q;
   logic          start;
   logic [WW-1:0] cnt_q;
   logic [WW-1:0] remaining;

   assign start     = bus_act && !act_q;
   assign remaining = start ? wsel : cnt_q;
   assign rdy       = !bus_act || !hit_any || ((remaining == '0) && !wait_in);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         cnt_q <= '0;
      end else begin
         act_q <= bus_act;
         if (!bus_act || !hit_any)
            cnt_q <= '0;
         else if (start)
            cnt_q <= (wsel == '0) ? '0 : wsel - 1'b1;
         else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/csel_wait_gen.sv
module csel_wait_gen
   import csw_pkg::*;
#(
   parameter int NCH     = CSW_CHANS,
   parameter int AW      = CSW_ADDR_W,
   parameter int FW      = CSW_FIELD_W,
   parameter int WW      = CSW_WAIT_W,
   parameter int MEM_LSB = 16,
   parameter int IO_LSB  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     addr,
   input  logic              mreq,
   input  logic              iorq,
   input  logic              rd,
   input  logic              wr,
   input  logic              wait_in,
   input  logic [NCH-1:0]    cfg_en,
   input  logic [NCH-1:0]    cfg_io,
   input  logic [NCH*FW-1:0] cfg_lo,
   input  logic [NCH*FW-1:0] cfg_hi,
   input  logic [NCH*WW-1:0] cfg_wait,
   output logic [NCH-1:0]    cs,
   output logic              rdy
);
   localparam int MEM_TOP = MEM_LSB + FW;
   localparam int IO_TOP  = IO_LSB + FW;

   if (NCH < 1 || NCH > 16) begin : g_bad_nch
      $error("csel_wait_gen: NCH out of range");
   end
   if (MEM_TOP > AW || IO_TOP > AW) begin : g_bad_field
      $error("csel_wait_gen: decode field outside address bus");
   end
   if (WW < 1) begin : g_bad_ww
      $error("csel_wait_gen: wait field too narrow");
   end

   logic [NCH-1:0] hit;
   logic [NCH-1:0] gnt;
   logic [WW-1:0]  wsel;
   logic           bus_act;

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      csw_chan_match #(
         .AW(AW), .FW(FW), .MEM_LSB(MEM_LSB), .IO_LSB(IO_LSB)
      ) u_match (
         .en   (cfg_en[c]),
         .space(cfg_io[c]),
         .lo   (cfg_lo[c*FW +: FW]),
         .hi   (cfg_hi[c*FW +: FW]),
         .addr (addr),
         .mreq (mreq),
         .iorq (iorq),
         .hit  (hit[c])
      );
   end

   csw_prio #(.N(NCH)) u_prio (
      .req(hit),
      .gnt(gnt)
   );

   always_comb begin
      wsel = '0;
      for (int i = 0; i < NCH; i++)
         if (gnt[i])
            wsel = cfg_wait[i*WW +: WW];
   end

   assign bus_act = (mreq || iorq) && (rd || wr);
   assign cs      = gnt;

   csw_wait_ctr #(.WW(WW)) u_wait (
      .clk    (clk),
      .rst_n  (rst_n),
      .bus_act(bus_act),
      .hit_any(|gnt),
      .wsel   (wsel),
      .wait_in(wait_in),
      .rdy    (rdy)
   );
endmodule

// File: rtl/csw_checker.sv
module csw_checker #(
   parameter int NCH = 4,
   parameter int WW  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mreq,
   input logic              iorq,
   input logic              rd,
   input logic              wr,
   input logic              wait_in,
   input logic [NCH-1:0]    cfg_en,
   input logic [NCH*WW-1:0] cfg_wait,
   input logic [NCH-1:0]    cs,
   input logic              rdy
);
   logic          act;
   logic          act_prev;
   logic [WW-1:0] cs_wait;

   assign act = (mreq || iorq) && (rd || wr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_prev <= 1'b0;
      else        act_prev <= act;
   end

   always_comb begin
      cs_wait = '0;
      for (int i = 0; i < NCH; i++)
         if (cs[i]) cs_wait = cfg_wait[i*WW +: WW];
   end

   assert_cs_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cs));
   assert_cs_needs_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(mreq || iorq) |-> (cs == '0));
   assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cs & ~cfg_en) == '0);
   assert_first_clock_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (act && !act_prev && (cs != '0) && (cs_wait != '0)) |-> !rdy);
   assert_wait_stalls_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (act && (cs != '0) && wait_in) |-> !rdy);
   assert_unmatched_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cs == '0) |-> rdy);
endmodule

bind csel_wait_gen csw_checker #(.NCH(NCH), .WW(WW)) u_csw_chk (
   .clk(clk), .rst_n(rst_n), .mreq(mreq), .iorq(iorq), .rd(rd), .wr(wr),
   .wait_in(wait_in), .cfg_en(cfg_en), .cfg_wait(cfg_wait), .cs(cs), .rdy(rdy)
);

// File: tb/tb_csel_wait_gen.sv
module tb_csel_wait_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] addr = '0;
   logic        mreq = 1'b0, iorq = 1'b0, rd = 1'b0, wr = 1'b0, wait_in = 1'b0;
   logic [3:0]  cfg_en = 4'b1111;
   logic [3:0]  cfg_io = 4'b0100;
   logic [31:0] cfg_lo = {8'h80, 8'h40, 8'h08, 8'h00};
   logic [31:0] cfg_hi = {8'h80, 8'h00, 8'h3F, 8'h0F};
   logic [11:0] cfg_wait = {3'd0, 3'd7, 3'd5, 3'd2};
   logic [3:0]  cs;
   logic        rdy;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   csel_wait_gen dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .mreq(mreq), .iorq(iorq),
      .rd(rd), .wr(wr), .wait_in(wait_in), .cfg_en(cfg_en), .cfg_io(cfg_io),
      .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_wait(cfg_wait), .cs(cs), .rdy(rdy)
   );

   // {addr, io, expected cs, expected stall clocks}
   localparam int NV = 12;
   localparam logic [32:0] VEC [NV] = '{
      {24'h000000, 1'b0, 4'b0001, 4'd2},   // R2 lower bound, R6
      {24'h0FFFFF, 1'b0, 4'b0001, 4'd2},   // R2 upper bound
      {24'h0A1234, 1'b0, 4'b0001, 4'd2},   // R4 overlap, ch0 wins
      {24'h100000, 1'b0, 4'b0010, 4'd5},   // R2 ch1
      {24'h3FFFFF, 1'b0, 4'b0010, 4'd5},   // R2 ch1 upper bound
      {24'h400000, 1'b0, 4'b0000, 4'd0},   // R8 above range
      {24'h805678, 1'b0, 4'b1000, 4'd0},   // R6 zero waits
      {24'h810000, 1'b0, 4'b0000, 4'd0},   // R8
      {24'h004000, 1'b1, 4'b0100, 4'd7},   // R3 I/O, max waits
      {24'h7740FF, 1'b1, 4'b0100, 4'd7},   // R3 upper byte ignored
      {24'h004100, 1'b1, 4'b0000, 4'd0},   // R3 wrong section
      {24'h000000, 1'b1, 4'b0000, 4'd0}    // R3 mem channel ignores iorq
   };

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic bus_cycle(input logic [23:0] a, input logic io, input logic use_wr,
                            input int wait_len, output logic [3:0] cs_seen,
                            output int stall);
      int k;
      @(negedge clk);
      addr = a; mreq = !io; iorq = io; rd = !use_wr; wr = use_wr;
      wait_in = (wait_len > 0);
      #2;
      cs_seen = cs;
      k = 0;
      while (!rdy && k < 40) begin
         k++;
         @(negedge clk);
         wait_in = (k < wait_len);
         #2;
      end
      stall = k;
      @(negedge clk);
      mreq = 1'b0; iorq = 1'b0; rd = 1'b0; wr = 1'b0; wait_in = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      #2000000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [3:0] cs_seen;
      int stall;
      repeat (3) @(negedge clk);
      #2;
      check("R9 cs after reset", int'(cs), 0);
      check("R9 rdy after reset", int'(rdy), 1);
      rst_n = 1'b1;
      @(negedge clk); #2;
      check("R9 idle cs", int'(cs), 0);
      check("R8 idle rdy", int'(rdy), 1);

      for (int v = 0; v < NV; v++) begin
         bus_cycle(VEC[v][32:9], VEC[v][8], v[0], 0, cs_seen, stall);
         check($sformatf("R1 R2 R3 R4 cs vector %0d", v), int'(cs_seen), int'(VEC[v][7:4]));
         check($sformatf("R6 stall vector %0d", v), stall, int'(VEC[v][3:0]));
      end

      // R7: WAIT longer than the count extends the cycle
      bus_cycle(24'h050000, 1'b0, 1'b0, 5, cs_seen, stall);
      check("R7 wait longer than count", stall, 5);
      // R7: WAIT inside the count adds nothing
      bus_cycle(24'h050000, 1'b0, 1'b1, 1, cs_seen, stall);
      check("R7 wait inside count", stall, 2);
      // R7: zero-wait channel stalled only by WAIT
      bus_cycle(24'h800000, 1'b0, 1'b0, 3, cs_seen, stall);
      check("R7 wait on zero-count channel", stall, 3);
      // R8: WAIT ignored on an unmatched cycle
      bus_cycle(24'h900000, 1'b0, 1'b0, 4, cs_seen, stall);
      check("R8 unmatched cs", int'(cs_seen), 0);
      check("R8 unmatched ignores wait", stall, 0);

      // R5: disable ch0, overlap address falls to ch1
      cfg_en = 4'b1110;
      bus_cycle(24'h090000, 1'b0, 1'b0, 0, cs_seen, stall);
      check("R5 disabled ch0 cs", int'(cs_seen), 2);
      check("R5 ch1 waits", stall, 5);
      bus_cycle(24'h020000, 1'b0, 1'b0, 0, cs_seen, stall);
      check("R5 disabled ch0 no select", int'(cs_seen), 0);
      check("R5 disabled ch0 no waits", stall, 0);
      cfg_en = 4'b1011;
      bus_cycle(24'h004000, 1'b1, 1'b0, 0, cs_seen, stall);
      check("R5 disabled I/O channel", int'(cs_seen), 0);
      check("R5 disabled I/O no waits", stall, 0);
      cfg_en = 4'b1111;

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule